// File: doc/BRIEF.md
# Broadcast configuration packet fan-out

This block turns a stream of 32-bit bus writes into 128-bit configuration packets and hands each packet to up to fifteen frame controllers at once. Each controller occupies one slot. A presence mask says which slots are populated, and only populated slots see a packet. Writes land in a four-word staging buffer. The word index comes from address bits 3:2. A write to word 3 completes the packet: that word is joined with the three stored words and sent out.

Writes reach the block through one of two windows, and the window select input picks between them. In the register window, address bits 9:4 give the target register select carried with the packet. In the data window, the select is always the frame data register code, set by a parameter. Neither window can be read. A read returns zero and raises an error flag for one cycle.

Top module: `bcast_fanout`

## Requirements
- R1: While reset is held and in the first cycle after it, no target valid is high, busErr is low and busRdata is zero.
- R2: A write to word 0, 1 or 2 (busAddr[3:2] = 0, 1, 2) stores busWdata in that staging word and causes no target valid.
- R3: A write to word 3 (busAddr[3:2] = 3) at clock edge N raises the valid of every present target for exactly the cycle after edge N. The packet data has word k in bits 32k+31:32k. Word 3 is the value just written. Words 0 to 2 are the stored staging words.
- R4: A packet fired through the register window (busWin = 0) carries busAddr[9:4] as its 6-bit register select.
- R5: A packet fired through the data window (busWin = 1) carries the FRAME_SEL code (default 6'h02) as its register select, whatever the address.
- R6: Target i raises valid only while presentMask[i] is 1. All present targets receive the same select and data in the same cycle.
- R7: A read (busEn = 1, busWe = 0) raises busErr for the one cycle after that edge. It changes neither the staging words nor any target output, and busRdata is always zero.
- R8: Reset clears all staging words. A word-3 write right after reset yields zeros in bits 95:0.
- R9: Firing a packet leaves words 0 to 2 in place. A later word-3 write alone reuses them.
- R10: Word-3 writes on consecutive edges produce valid on consecutive cycles, one pulse per write, each pulse carrying that write's data and select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Bus access strobe, one access per cycle |
| busWe | input | 1 | 1 for a write, 0 for a read |
| busWin | input | 1 | 0 selects the register window, 1 the data window |
| busAddr | input | 12 | Byte offset inside the 4 KiB window |
| busWdata | input | 32 | Write data, little-endian word |
| busRdata | output | 32 | Read data, always zero |
| busErr | output | 1 | One-cycle pulse after an unsupported read |
| presentMask | input | 15 | One bit per populated target slot |
| tgtValid | output | 15 | Per-target packet valid pulse |
| tgtSel | output | 90 | Per-target 6-bit register select, slot i in bits 6i+5:6i |
| tgtData | output | 1920 | Per-target 128-bit packet, slot i in bits 128i+127:128i |

## Verification
The checker watches a few things on every cycle. It confirms that absent slots stay silent and that valid follows only a word-3 write. It checks the select on slot 0 against the window and address of the firing write, and the top data word against the written value. It also checks that reads produce the error pulse and never a packet. Some behaviour can only be seen across several writes: the buffer retaining words after a fire, reset clearing them, and back-to-back pulses. The bench's reference model checks these by following the staging words through directed sequences and a long random mix of windows, addresses and masks.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
  localparam int SEL_W   = 6;
  localparam int WORD_W  = 32;
  localparam int WORDS   = 4;
  localparam int PKT_W   = WORD_W * WORDS;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic [WORDS-2:0] wordLd;  // store into staging word 0..2
    logic             fire;    // word 3 written: launch packet
    logic [SEL_W-1:0] sel;     // register select for the packet
    logic             rdErr;   // unsupported read seen
  } bcast_strobe_t;
endpackage

// File: rtl/bcast_ctrl.sv
module bcast_ctrl
  import bcast_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter logic [SEL_W-1:0] FRAME_SEL = 6'h02
) (
  input  logic              busEn,
  input  logic              busWe,
  input  logic              busWin,
  input  logic [ADDR_W-1:0] busAddr,
  output bcast_strobe_t     strb
);
  localparam int IDX_LO = 2;
  localparam int SEL_LO = 4;

  logic [1:0] wordIdx;
  logic       unusedAddr;

  assign wordIdx    = busAddr[IDX_LO +: 2];
  assign unusedAddr = ^{busAddr[ADDR_W-1:SEL_LO+SEL_W], busAddr[IDX_LO-1:0]};

  always_comb begin
    strb = '0;
    if (busEn) begin
      if (busWe) begin
        strb.sel = busWin ? FRAME_SEL : busAddr[SEL_LO +: SEL_W];
        if (wordIdx == 2'(WORDS - 1)) begin
          strb.fire = 1'b1;
        end else begin
          strb.wordLd[wordIdx] = 1'b1;
        end
      end else begin
        strb.rdErr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcast_datapath.sv
module bcast_datapath
  import bcast_pkg::*;
#(
  parameter int NUM_TGT = 15
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bcast_strobe_t            strb,
  input  logic [WORD_W-1:0]        busWdata,
  input  logic [NUM_TGT-1:0]       presentMask,
  output logic                     busErr,
  output logic [NUM_TGT-1:0]       tgtValid,
  output logic [NUM_TGT*SEL_W-1:0] tgtSel,
  output logic [NUM_TGT*PKT_W-1:0] tgtData
);
  logic [WORDS-2:0][WORD_W-1:0] stage;
  logic                         pktVld;
  logic [SEL_W-1:0]             pktSel;
  logic [PKT_W-1:0]             pktData;

  for (genvar w = 0; w < WORDS - 1; w++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[w] <= '0;
      end else if (strb.wordLd[w]) begin
        stage[w] <= busWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktVld  <= 1'b0;
      pktSel  <= '0;
      pktData <= '0;
      busErr  <= 1'b0;
    end else begin
      pktVld <= strb.fire;
      busErr <= strb.rdErr;
      if (strb.fire) begin
        pktSel  <= strb.sel;
        pktData <= {busWdata, stage};
      end
    end
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_fan
    assign tgtValid[t]                = pktVld & presentMask[t];
    assign tgtSel[t*SEL_W +: SEL_W]   = pktSel;
    assign tgtData[t*PKT_W +: PKT_W]  = pktData;
  end
endmodule

// File: rtl/bcast_fanout.sv
module bcast_fanout
  import bcast_pkg::*;
#(
  parameter int               NUM_TGT   = 15,
  parameter int               ADDR_W    = 12,
  parameter logic [SEL_W-1:0] FRAME_SEL = 6'h02
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busEn,
  input  logic                     busWe,
  input  logic                     busWin,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [WORD_W-1:0]        busWdata,
  output logic [WORD_W-1:0]        busRdata,
  output logic                     busErr,
  input  logic [NUM_TGT-1:0]       presentMask,
  output logic [NUM_TGT-1:0]       tgtValid,
  output logic [NUM_TGT*SEL_W-1:0] tgtSel,
  output logic [NUM_TGT*PKT_W-1:0] tgtData
);
  bcast_strobe_t strb;

  assign busRdata = '0;

  bcast_ctrl #(.ADDR_W(ADDR_W), .FRAME_SEL(FRAME_SEL)) u_ctrl (
    .busEn  (busEn),
    .busWe  (busWe),
    .busWin (busWin),
    .busAddr(busAddr),
    .strb   (strb)
  );

  bcast_datapath #(.NUM_TGT(NUM_TGT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWdata   (busWdata),
    .presentMask(presentMask),
    .busErr     (busErr),
    .tgtValid   (tgtValid),
    .tgtSel     (tgtSel),
    .tgtData    (tgtData)
  );
endmodule

// File: rtl/bcast_fanout_chk.sv
module bcast_fanout_chk
  import bcast_pkg::*;
#(
  parameter int               NUM_TGT   = 15,
  parameter int               ADDR_W    = 12,
  parameter logic [SEL_W-1:0] FRAME_SEL = 6'h02
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     busEn,
  input logic                     busWe,
  input logic                     busWin,
  input logic [ADDR_W-1:0]        busAddr,
  input logic [WORD_W-1:0]        busWdata,
  input logic [WORD_W-1:0]        busRdata,
  input logic                     busErr,
  input logic [NUM_TGT-1:0]       presentMask,
  input logic [NUM_TGT-1:0]       tgtValid,
  input logic [NUM_TGT*SEL_W-1:0] tgtSel,
  input logic [NUM_TGT*PKT_W-1:0] tgtData
);
  // R6
  absent_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid & ~presentMask) == '0);

  // R2
  partial_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && busWe && busAddr[3:2] != 2'd3) |=> (tgtValid == '0));

  // R3
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid != '0) |-> $past(busEn && busWe && busAddr[3:2] == 2'd3));

  // R3
  top_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtValid[0] |-> (tgtData[PKT_W-1 -: WORD_W] == $past(busWdata)));

  // R4
  reg_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid[0] && !$past(busWin)) |-> (tgtSel[SEL_W-1:0] == $past(busAddr[9:4])));

  // R5
  data_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tgtValid[0] && $past(busWin)) |-> (tgtSel[SEL_W-1:0] == FRAME_SEL));

  // R7
  read_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !busWe) |=> (busErr && tgtValid == '0));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busEn && !busWe));

  // R7
  rdata_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdata == '0);
endmodule

bind bcast_fanout bcast_fanout_chk #(
  .NUM_TGT(NUM_TGT), .ADDR_W(ADDR_W), .FRAME_SEL(FRAME_SEL)
) u_chk (
  .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busWin(busWin),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
  .presentMask(presentMask), .tgtValid(tgtValid), .tgtSel(tgtSel), .tgtData(tgtData)
);

// File: tb/tb_bcast_fanout.sv
`timescale 1ns/1ps
module tb_bcast_fanout;
  localparam int NT = 15;
  localparam int SW = 6;
  localparam int PW = 128;
  localparam logic [5:0] FSEL = 6'h02;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            busEn = 1'b0, busWe = 1'b0, busWin = 1'b0;
  logic [11:0]     busAddr = '0;
  logic [31:0]     busWdata = '0;
  logic [31:0]     busRdata;
  logic            busErr;
  logic [NT-1:0]   presentMask = '1;
  logic [NT-1:0]   tgtValid;
  logic [NT*SW-1:0] tgtSel;
  logic [NT*PW-1:0] tgtData;

  bcast_fanout dut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busWin(busWin),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .presentMask(presentMask), .tgtValid(tgtValid), .tgtSel(tgtSel), .tgtData(tgtData)
  );

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  // behavioural reference
  logic [31:0]  refStage [3];
  logic         expVld;
  logic [5:0]   expSel;
  logic [127:0] expData;
  logic         expErr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 3; k++) refStage[k] = '0;
      expVld = 1'b0; expErr = 1'b0; expSel = '0; expData = '0;
    end else begin
      expVld = 1'b0;
      expErr = 1'b0;
      if (busEn && !busWe) expErr = 1'b1;
      if (busEn && busWe) begin
        if (busAddr[3:2] == 2'd3) begin
          expVld  = 1'b1;
          expSel  = busWin ? FSEL : busAddr[9:4];
          expData = {busWdata, refStage[2], refStage[1], refStage[0]};
        end else begin
          refStage[busAddr[3:2]] = busWdata;
        end
      end
    end
  end

  always @(negedge clk) begin
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < NT; i++) begin
      logic ev;
      ev = expVld & presentMask[i];
      if (tgtValid[i] !== ev) begin
        $display("FAIL %s: tgtValid[%0d] actual %b expected %b", curReq, i, tgtValid[i], ev);
        bad = 1'b1;
      end
      if (ev && tgtSel[i*SW +: SW] !== expSel) begin
        $display("FAIL %s: tgtSel[%0d] actual %h expected %h", curReq, i, tgtSel[i*SW +: SW], expSel);
        bad = 1'b1;
      end
      if (ev && tgtData[i*PW +: PW] !== expData) begin
        $display("FAIL %s: tgtData[%0d] actual %h expected %h", curReq, i, tgtData[i*PW +: PW], expData);
        bad = 1'b1;
      end
    end
    if (busErr !== expErr) begin
      $display("FAIL %s: busErr actual %b expected %b", curReq, busErr, expErr);
      bad = 1'b1;
    end
    if (busRdata !== 32'h0) begin
      $display("FAIL %s: busRdata actual %h expected 0", curReq, busRdata);
      bad = 1'b1;
    end
    compared++;
    if (bad) mismatched++;
  end

  task automatic drive(input logic en, input logic we, input logic win,
                       input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busEn = en; busWe = we; busWin = win; busAddr = a; busWdata = d;
  endtask

  task automatic wr(input logic win, input logic [11:0] a, input logic [31:0] d);
    drive(1'b1, 1'b1, win, a, d);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 1'b0, 12'h0, 32'h0);
  endtask

  task automatic packet(input logic win, input logic [11:0] base, input logic [31:0] seed);
    for (int k = 0; k < 4; k++) wr(win, base + 12'(4 * k), seed + 32'(k));
  endtask

  initial begin
    #2_000_000;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    mismatched++;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1 reset state
    curReq = "R1";
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    idle(2);

    // R3 R4 register window packet, all slots present
    curReq = "R4";
    packet(1'b0, 12'h230, 32'hA000_0000);
    idle(2);
    packet(1'b0, 12'hFF0, 32'h1234_5670);
    idle(1);

    // R5 data window, select forced
    curReq = "R5";
    packet(1'b1, 12'h7F0, 32'hD000_0010);
    packet(1'b1, 12'h000, 32'hD000_0020);
    idle(1);

    // R6 sparse and empty masks
    curReq = "R6";
    presentMask = 15'h5A5A;
    packet(1'b0, 12'h110, 32'h6600_0000);
    presentMask = 15'h0001;
    packet(1'b0, 12'h120, 32'h6700_0000);
    presentMask = '0;
    packet(1'b1, 12'h130, 32'h6800_0000);
    idle(1);
    presentMask = '1;

    // R2 partial writes only
    curReq = "R2";
    wr(1'b0, 12'h040, 32'hBEEF_0000);
    wr(1'b0, 12'h044, 32'hBEEF_0001);
    wr(1'b1, 12'h048, 32'hBEEF_0002);
    idle(3);

    // R7 reads between writes do not disturb staging
    curReq = "R7";
    drive(1'b1, 1'b0, 1'b0, 12'h04C, 32'hFFFF_FFFF);
    drive(1'b1, 1'b0, 1'b1, 12'h000, 32'h0);
    wr(1'b0, 12'h04C, 32'hBEEF_0003);
    idle(2);

    // R9 retained words, word 3 alone
    curReq = "R9";
    wr(1'b0, 12'h05C, 32'h9999_0001);
    idle(1);
    wr(1'b1, 12'h00C, 32'h9999_0002);
    idle(1);

    // R10 back-to-back word-3 writes
    curReq = "R10";
    wr(1'b0, 12'h01C, 32'hAAAA_0001);
    wr(1'b1, 12'h02C, 32'hAAAA_0002);
    wr(1'b0, 12'h3FC, 32'hAAAA_0003);
    idle(2);

    // R8 reset clears staging
    curReq = "R8";
    packet(1'b0, 12'h200, 32'h8888_0000);
    wr(1'b0, 12'h200, 32'h7777_0000);
    idle(1);
    #2 rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    wr(1'b0, 12'h20C, 32'h8888_FFFF);
    idle(2);

    // R3 random mix of windows, offsets, reads and masks
    curReq = "R3";
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) presentMask = 15'($urandom);
      drive(r[4] | r[5], r[6] | r[7], r[8], 12'($urandom), $urandom);
    end
    idle(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule